// File: doc/BRIEF.md
# Four-Channel PCM Serial Port

This block carries 8-bit companded voice samples for four channels over one shared serial highway. Each channel has a parallel transmit byte and a parallel receive holding register. On the transmit side the port shifts bytes onto `dx`, together with an output enable and a per-channel time-slot indicator. On the receive side it collects bits from `dr` into the holding registers. One bit clock times everything. Transmit data changes after the rising edge. Receive data is sampled on the falling edge.

The `wide_mode` input selects one of two framing schemes:

- **Narrow framing.** Each channel has its own transmit and receive frame sync, and that sync alone places the channel's slot.
- **Wide framing.** Channel 0's syncs start a 32-bit frame, and channels 0 to 3 follow one another in four back-to-back slots.

The `long_sync` input chooses how a sync pulse is read:

- **Long sync.** The sync is held high across the slot, and the first bit follows the edge that first sees it high.
- **Short sync.** The sync is a one-clock pulse one bit ahead of the slot.

Every channel has one transmit lane and one receive lane. Each lane is a two-state machine with the states IDLE and SHIFT:

- IDLE to SHIFT on a start.
- SHIFT to SHIFT while bits remain.
- SHIFT to IDLE after bit 0 when no start is present.
- SHIFT to SHIFT, with a reload, after bit 0 when a start arrives on the same edge.

Top module: `pcm_quad_port`

## Requirements
- R1: `wide_mode` high selects the 32-bit frame, and `wide_mode` low selects four independent 8-bit slots.
- R2: With `wide_mode` low, channel k's slot is set only by `fs_tx[k]` and `fs_rx[k]`, and no other channel drives during it.
- R3: With `wide_mode` high, only `fs_tx[0]` and `fs_rx[0]` start a frame, and syncs on channels 1 to 3 are ignored. Channels 0, 1, 2 and 3 then take consecutive 8-bit slots in that order, with no gap between them. `dx_oe` falls after the last slot.
- R4: Each slot carries its byte most significant bit first, bit 7 down to bit 0, on both `dx` and `dr`. Channel k's byte is `tx_bytes[8k+7:8k]`, and likewise in `rx_bytes`.
- R5: With `long_sync` high, bit 7 is on `dx` in the clock cycle right after the rising edge that first samples the sync high. With `long_sync` low, the sync is a one-cycle pulse, the cycle after its sampling edge carries no data, and bit 7 appears one cycle later.
- R6: `slot_ts[k]` is high exactly while channel k's bits are on `dx`. `dx_oe` is high while any `slot_ts` bit is set. `dx` reads 0 while `dx_oe` is low.
- R7: After bit 0 of a receive slot is taken, `rx_bytes` holds the received byte for that channel. In the following cycle `rx_valid[k]` is high for exactly one cycle.
- R8: `dr` is sampled on the falling edge of `clk` in the middle of each bit cell.
- R9: While `rst_n` is low, `dx_oe`, `slot_ts`, `rx_valid` and `rx_bytes` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 1: one 32-bit frame started by channel 0; 0: per-channel slots |
| long_sync | input | 1 | 1: long frame sync; 0: short frame sync |
| fs_tx | input | 4 | Transmit frame sync, one per channel |
| fs_rx | input | 4 | Receive frame sync, one per channel |
| tx_bytes | input | 32 | Transmit bytes, channel k in bits 8k+7:8k |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Output enable for `dx` (tri-state control) |
| slot_ts | output | 4 | Per-channel time-slot indicator |
| rx_bytes | output | 32 | Receive holding registers, channel k in bits 8k+7:8k |
| rx_valid | output | 4 | One-cycle strobe per channel after a byte is received |

## Verification
The bench checks that bit 7 lands in exactly the right cycle for both sync styles. A design that swapped or misaligned the sync styles would show `dx_oe` one cycle early or late, and every bit would then be offset. Wide frames are driven with syncs held high on channels 1 to 3 at the same time. A design that did not gate those syncs would light several `slot_ts` bits at once, and a broken chain would leave a gap or repeat a slot. The received bytes carry asymmetric bit patterns, so a reversed bit order, or a sample taken one cycle early or late, corrupts the holding register. A valid strobe that lasts more than one cycle is also caught.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic {
        LANE_IDLE  = 1'b0,
        LANE_SHIFT = 1'b1
    } lane_state_e;
endpackage

// File: rtl/pcm_frame_start.sv
// Turns a frame sync line into a one-cycle start for a lane.
module pcm_frame_start (
    input  logic clk,
    input  logic rst_n,
    input  logic long_sync,
    input  logic fs,
    output logic start
);
    logic fs_d;
    logic fs_dd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_d  <= 1'b0;
            fs_dd <= 1'b0;
        end else begin
            fs_d  <= fs;
            fs_dd <= fs_d;
        end
    end

    // long: slot begins at the edge that first sees sync high
    // short: slot begins one edge later
    always_comb begin
        start = long_sync ? (fs & ~fs_d) : (fs_d & ~fs_dd);
    end

    AST_SHORT_LAGS: assert property (@(posedge clk) disable iff (!rst_n) (!long_sync && start) |-> $past(fs)); // R5
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] byte_in,
    output logic             bit_out,
    output logic             active,
    output logic             last
);
    localparam int CW = $clog2(WIDTH);

    lane_state_e      state, state_nx;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] sreg;

    always_comb begin
        state_nx = state;
        unique case (state)
            LANE_IDLE:  if (start) state_nx = LANE_SHIFT;
            LANE_SHIFT: if (cnt == '0 && !start) state_nx = LANE_IDLE;
            default:    state_nx = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LANE_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (start && (state == LANE_IDLE || cnt == '0)) begin
            sreg <= byte_in;
            cnt  <= CW'(WIDTH - 1);
        end else if (state == LANE_SHIFT) begin
            sreg <= {sreg[WIDTH-2:0], 1'b0};
            cnt  <= cnt - 1'b1;
        end
    end

    always_comb begin
        active  = (state == LANE_SHIFT);
        last    = active && (cnt == '0);
        bit_out = active & sreg[WIDTH-1];
    end

    AST_MSB_LEADS: assert property (@(posedge clk) disable iff (!rst_n) (start && !active) |=> (bit_out == $past(byte_in[WIDTH-1]))); // R4
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dr_s,
    output logic [WIDTH-1:0] hold,
    output logic             valid,
    output logic             last
);
    localparam int CW = $clog2(WIDTH);

    lane_state_e      state, state_nx;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] sreg;

    always_comb begin
        state_nx = state;
        unique case (state)
            LANE_IDLE:  if (start) state_nx = LANE_SHIFT;
            LANE_SHIFT: if (cnt == '0 && !start) state_nx = LANE_IDLE;
            default:    state_nx = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LANE_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg  <= '0;
            cnt   <= '0;
            hold  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (state == LANE_SHIFT) begin
                sreg <= {sreg[WIDTH-2:0], dr_s};
                if (cnt == '0) begin
                    hold  <= {sreg[WIDTH-2:0], dr_s};
                    valid <= 1'b1;
                    cnt   <= CW'(WIDTH - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (start) begin
                cnt <= CW'(WIDTH - 1);
            end
        end
    end

    always_comb begin
        last = (state == LANE_SHIFT) && (cnt == '0);
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid); // R7
    AST_VALID_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n) valid |-> $past(state == LANE_SHIFT)); // R7
endmodule

// File: rtl/pcm_quad_port.sv
module pcm_quad_port #(
    parameter int NCH   = 4,
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_mode,
    input  logic               long_sync,
    input  logic [NCH-1:0]     fs_tx,
    input  logic [NCH-1:0]     fs_rx,
    input  logic [NCH*WIDTH-1:0] tx_bytes,
    input  logic               dr,
    output logic               dx,
    output logic               dx_oe,
    output logic [NCH-1:0]     slot_ts,
    output logic [NCH*WIDTH-1:0] rx_bytes,
    output logic [NCH-1:0]     rx_valid
);
    logic           dr_s;
    logic [NCH-1:0] tx_sync, rx_sync;
    logic [NCH-1:0] tx_start, rx_start;
    logic [NCH-1:0] tx_bit, tx_act, tx_last, rx_last;

    // receive data taken mid-cell on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) dr_s <= 1'b0;
        else        dr_s <= dr;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        pcm_frame_start u_tx_det (
            .clk(clk), .rst_n(rst_n), .long_sync(long_sync),
            .fs(fs_tx[k]), .start(tx_sync[k])
        );
        pcm_frame_start u_rx_det (
            .clk(clk), .rst_n(rst_n), .long_sync(long_sync),
            .fs(fs_rx[k]), .start(rx_sync[k])
        );

        if (k == 0) begin : g_head
            assign tx_start[k] = tx_sync[k];
            assign rx_start[k] = rx_sync[k];
        end else begin : g_chain
            assign tx_start[k] = wide_mode ? tx_last[k-1] : tx_sync[k];
            assign rx_start[k] = wide_mode ? rx_last[k-1] : rx_sync[k];
        end

        pcm_tx_lane #(.WIDTH(WIDTH)) u_tx (
            .clk(clk), .rst_n(rst_n), .start(tx_start[k]),
            .byte_in(tx_bytes[k*WIDTH +: WIDTH]),
            .bit_out(tx_bit[k]), .active(tx_act[k]), .last(tx_last[k])
        );
        pcm_rx_lane #(.WIDTH(WIDTH)) u_rx (
            .clk(clk), .rst_n(rst_n), .start(rx_start[k]), .dr_s(dr_s),
            .hold(rx_bytes[k*WIDTH +: WIDTH]), .valid(rx_valid[k]),
            .last(rx_last[k])
        );

        if (k < NCH - 1) begin : g_chk
            AST_WIDE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) (wide_mode && $stable(wide_mode) && tx_last[k]) |=> tx_act[k+1]); // R3
        end
    end

    always_comb begin
        dx      = |tx_bit;
        dx_oe   = |tx_act;
        slot_ts = tx_act;
    end

    AST_SINGLE_TALKER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_act)); // R6
    AST_WIDE_TAIL: assert property (@(posedge clk) disable iff (!rst_n) (wide_mode && $stable(wide_mode) && tx_last[NCH-1]) |=> !tx_act[NCH-1]); // R3
    AST_RX_TAIL: assert property (@(posedge clk) disable iff (!rst_n) rx_last[NCH-1] |=> rx_valid[NCH-1]); // R7
endmodule

// File: tb/pcm_quad_port_test.sv
`timescale 1ns/1ps
module pcm_quad_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        long_sync = 1'b1;
    logic [3:0]  fs_tx = '0;
    logic [3:0]  fs_rx = '0;
    logic [31:0] tx_bytes = '0;
    logic        dr = 1'b0;
    logic        dx, dx_oe;
    logic [3:0]  slot_ts, rx_valid;
    logic [31:0] rx_bytes;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pcm_quad_port uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .long_sync(long_sync),
        .fs_tx(fs_tx), .fs_rx(fs_rx), .tx_bytes(tx_bytes), .dr(dr),
        .dx(dx), .dx_oe(dx_oe), .slot_ts(slot_ts), .rx_bytes(rx_bytes),
        .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            fs_tx = '0; fs_rx = '0; dr = 1'b0;
            @(negedge clk);
            chk(dx_oe == 1'b0 && dx == 1'b0, "R6 idle quiet", {30'd0, dx_oe, dx}, 32'd0);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(dx_oe == 1'b0, "R9 oe", {31'd0, dx_oe}, 32'd0);
        chk(slot_ts == 4'd0, "R9 ts", {28'd0, slot_ts}, 32'd0);
        chk(rx_valid == 4'd0, "R9 valid", {28'd0, rx_valid}, 32'd0);
        chk(rx_bytes == 32'd0, "R9 rx", rx_bytes, 32'd0);
        rst_n = 1'b1;
        idle(2);
    endtask

    // R2 R4 R5 R6 R7 R8: one channel's slot in narrow framing
    task automatic narrow_frame(input int ch, input bit lng, input logic [7:0] tb, input logic [7:0] rb);
        @(posedge clk); #1;
        wide_mode = 1'b0; long_sync = lng;
        tx_bytes[ch*8 +: 8] = tb;
        fs_tx[ch] = 1'b1; fs_rx[ch] = 1'b1;
        if (!lng) begin
            @(posedge clk); #1;
            fs_tx = '0; fs_rx = '0;
            @(negedge clk);
            chk(dx_oe == 1'b0, "R5 short gap", {31'd0, dx_oe}, 32'd0);
        end
        for (int i = 7; i >= 0; i--) begin
            @(posedge clk); #1;
            dr = rb[i];
            @(negedge clk);
            chk(dx === tb[i] && dx_oe === 1'b1, "R4 R5 dx bit", {30'd0, dx_oe, dx}, {30'd0, 1'b1, tb[i]});
            chk(slot_ts == (4'd1 << ch), "R2 R6 slot", {28'd0, slot_ts}, {28'd0, 4'd1 << ch});
        end
        @(posedge clk); #1;
        fs_tx = '0; fs_rx = '0; dr = 1'b0;
        @(negedge clk);
        chk(rx_valid == (4'd1 << ch), "R7 valid", {28'd0, rx_valid}, {28'd0, 4'd1 << ch});
        chk(rx_bytes[ch*8 +: 8] == rb, "R7 R8 rx byte", {24'd0, rx_bytes[ch*8 +: 8]}, {24'd0, rb});
        chk(dx_oe == 1'b0, "R6 oe drops", {31'd0, dx_oe}, 32'd0);
        @(posedge clk); #1;
        @(negedge clk);
        chk(rx_valid == 4'd0, "R7 one cycle", {28'd0, rx_valid}, 32'd0);
    endtask

    // R1 R3: one 32-bit frame, with syncs of channels 1..3 held high to be ignored
    task automatic wide_frame(input bit lng, input logic [31:0] tb, input logic [31:0] rb);
        @(posedge clk); #1;
        wide_mode = 1'b1; long_sync = lng;
        tx_bytes = tb;
        fs_tx = 4'b1111; fs_rx = 4'b1111;
        if (!lng) begin
            @(posedge clk); #1;
            fs_tx = 4'b1110; fs_rx = 4'b1110;
            @(negedge clk);
            chk(dx_oe == 1'b0, "R5 short gap wide", {31'd0, dx_oe}, 32'd0);
        end
        for (int j = 0; j < 32; j++) begin
            int ch = j / 8;
            int b  = ch * 8 + 7 - (j % 8);
            @(posedge clk); #1;
            dr = rb[b];
            @(negedge clk);
            chk(dx === tb[b] && dx_oe === 1'b1, "R3 R4 wide dx", {30'd0, dx_oe, dx}, {30'd0, 1'b1, tb[b]});
            chk(slot_ts == (4'd1 << ch), "R1 R3 wide slot", {28'd0, slot_ts}, {28'd0, 4'd1 << ch});
        end
        @(posedge clk); #1;
        fs_tx = '0; fs_rx = '0; dr = 1'b0;
        @(negedge clk);
        chk(dx_oe == 1'b0, "R3 frame ends", {31'd0, dx_oe}, 32'd0);
        chk(rx_valid == 4'b1000, "R3 R7 last valid", {28'd0, rx_valid}, 32'h8);
        chk(rx_bytes == rb, "R3 R8 rx frame", rx_bytes, rb);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        narrow_frame(0, 1'b1, 8'hA5, 8'h3C);
        idle(3);
        narrow_frame(2, 1'b0, 8'h81, 8'hE1);
        idle(2);
        narrow_frame(3, 1'b1, 8'h1E, 8'h96);
        idle(2);
        wide_frame(1'b1, 32'h8142_C3A5, 32'h0F1E_D2B4);
        idle(3);
        wide_frame(1'b0, 32'h1234_9ABC, 32'hC0FF_EE71);
        idle(3);
        narrow_frame(1, 1'b0, 8'h6D, 8'h59);
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule